// File: doc/BRIEF.md
# Peripheral Clock Enable Controller

This block keeps one clock-enable flag for each peripheral slot and drives them out as a vector, one bit per peripheral. The bit index is the peripheral's identifier, which in normal use is the same number as that peripheral's interrupt source. Downstream gating cells use the vector. Checking that a peripheral is idle before its clock is removed is left to software.

Software reaches the one shared state vector through three register views on a small word-addressed bus. A write-one-to-set view turns clocks on. A write-one-to-clear view turns them off. A read-only status view returns the current enables. Zero bits in a write leave their enables as they are. Only positions marked in an implementation mask hold a flop; all other positions are hard zero.

Top module: `pclk_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `clk_en_o` and `rd_data_o` becomes 0, whatever the bus inputs are.
- R2: A write with `wr_addr` = 0 (set view) turns on, at the next rising edge, every implemented enable whose `wr_data` bit is 1.
- R3: A write with `wr_addr` = 1 (clear view) turns off, at the next rising edge, every enable whose `wr_data` bit is 1.
- R4: A `wr_data` bit of 0 in a set or clear write leaves that enable unchanged.
- R5: Disabling takes effect at once. The `clk_en_o` bit is low right after the edge that accepts the clear write, with no added delay.
- R6: A read with `rd_addr` = 2 (status view) puts the enable vector on `rd_data_o` after the next rising edge. A read of address 0, 1 or 3 returns zero there.
- R7: Bit positions that are 0 in `IMPL_MASK` read as 0 on `clk_en_o` and in status, and set writes do not change them.
- R8: A write to address 2 or 3 changes no enable.
- R9: `rd_data_o` holds its value in every cycle with `rd_en` low.
- R10: A status read in the same cycle as a set or clear write returns the enables as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write register select: 0 set, 1 clear, 2 status, 3 unused |
| wr_data | input | N_PERIPH | Write data, one bit per peripheral identifier |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_addr | input | 2 | Read register select, same encoding as the write select |
| rd_data_o | output | N_PERIPH | Registered read data |
| clk_en_o | output | N_PERIPH | Registered peripheral clock-enable vector |

## Verification
A set or clear write shows on `clk_en_o` after exactly one rising edge. A read shows on `rd_data_o` after exactly one rising edge, and it holds the enables as they stood before that edge. The bench drives each stimulus on a falling edge. It moves its reference model forward at the next rising edge: the read result is taken from the old model state before any write is applied. It compares both outputs shortly after that edge, so every result is checked in the cycle it is due and the same-cycle read/write order is exercised directly.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_SET  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CLR  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_NONE = 2'd3;
endpackage

// File: rtl/pclk_decode.sv
module pclk_decode
  import pclk_pkg::*;
#(
  parameter int N_PERIPH = 32
) (
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_addr,
  input  logic [N_PERIPH-1:0] wr_data,
  output logic [N_PERIPH-1:0] set_vec,
  output logic [N_PERIPH-1:0] clr_vec
);
  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (wr_en) begin
      case (wr_addr)
        SEL_SET: set_vec = wr_data;
        SEL_CLR: clr_vec = wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pclk_state.sv
module pclk_state #(
  parameter int                   N_PERIPH  = 32,
  parameter logic [N_PERIPH-1:0]  IMPL_MASK = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PERIPH-1:0] set_vec,
  input  logic [N_PERIPH-1:0] clr_vec,
  output logic [N_PERIPH-1:0] en_q
);
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst)             en_q[i] <= 1'b0;
        else if (clr_vec[i]) en_q[i] <= 1'b0;
        else if (set_vec[i]) en_q[i] <= 1'b1;
      end
    end else begin : g_rsvd
      assign en_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pclk_readback.sv
module pclk_readback
  import pclk_pkg::*;
#(
  parameter int N_PERIPH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [SEL_W-1:0]    rd_addr,
  input  logic [N_PERIPH-1:0] en_q,
  output logic [N_PERIPH-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= (rd_addr == SEL_STAT) ? en_q : '0;
  end
endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
#(
  parameter int                  N_PERIPH  = 32,
  parameter logic [N_PERIPH-1:0] IMPL_MASK = 32'h3FFF_FFFC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_addr,
  input  logic [N_PERIPH-1:0] wr_data,
  input  logic                rd_en,
  input  logic [SEL_W-1:0]    rd_addr,
  output logic [N_PERIPH-1:0] rd_data_o,
  output logic [N_PERIPH-1:0] clk_en_o
);
  logic [N_PERIPH-1:0] set_vec;
  logic [N_PERIPH-1:0] clr_vec;
  logic [N_PERIPH-1:0] en_q;

  pclk_decode #(.N_PERIPH(N_PERIPH)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .set_vec (set_vec),
    .clr_vec (clr_vec)
  );

  pclk_state #(.N_PERIPH(N_PERIPH), .IMPL_MASK(IMPL_MASK)) u_state (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .en_q    (en_q)
  );

  pclk_readback #(.N_PERIPH(N_PERIPH)) u_readback (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .en_q    (en_q),
    .rd_q    (rd_data_o)
  );

  assign clk_en_o = en_q;
endmodule

// File: rtl/pclk_ctrl_chk.sv
module pclk_ctrl_chk
  import pclk_pkg::*;
#(
  parameter int                  N_PERIPH  = 32,
  parameter logic [N_PERIPH-1:0] IMPL_MASK = 32'h3FFF_FFFC
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [SEL_W-1:0]    wr_addr,
  input logic [N_PERIPH-1:0] wr_data,
  input logic                rd_en,
  input logic [SEL_W-1:0]    rd_addr,
  input logic [N_PERIPH-1:0] rd_data_o,
  input logic [N_PERIPH-1:0] clk_en_o
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_d) begin
      rst_clear_chk: assert (clk_en_o == '0 && rd_data_o == '0);
    end
  end

  // R2
  set_on_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_SET) |=>
      ((clk_en_o & $past(wr_data) & IMPL_MASK) == ($past(wr_data) & IMPL_MASK)));

  // R3
  clr_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_CLR) |=> ((clk_en_o & $past(wr_data)) == '0));

  // R4
  zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == SEL_SET || wr_addr == SEL_CLR)) |=>
      ((clk_en_o & ~$past(wr_data)) == ($past(clk_en_o) & ~$past(wr_data))));

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((clk_en_o & ~IMPL_MASK) == '0));

  // R8
  no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == SEL_SET || wr_addr == SEL_CLR)) |=> $stable(clk_en_o));

  // R6
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == SEL_STAT) |=> (rd_data_o == $past(clk_en_o)));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data_o));
endmodule

bind pclk_ctrl pclk_ctrl_chk #(.N_PERIPH(N_PERIPH), .IMPL_MASK(IMPL_MASK)) u_chk (.*);

// File: tb/tb_pclk_ctrl.sv
`timescale 1ns/1ps
module tb_pclk_ctrl;
  localparam int                  N    = 32;
  localparam logic [N-1:0]        MASK = 32'h3FFF_FFFC;

  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [N-1:0] wr_data;
  logic         rd_en;
  logic [1:0]   rd_addr;
  logic [N-1:0] rd_data_o;
  logic [N-1:0] clk_en_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_en;
  logic [N-1:0] exp_rd;

  always #2.5 clk = ~clk;

  pclk_ctrl #(.N_PERIPH(N), .IMPL_MASK(MASK)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data_o(rd_data_o), .clk_en_o(clk_en_o)
  );

  function automatic logic [N-1:0] next_en(logic [N-1:0] cur, logic we,
                                           logic [1:0] a, logic [N-1:0] d);
    if (we && a == 2'd0) return cur | (d & MASK);
    if (we && a == 2'd1) return cur & ~d;
    return cur;
  endfunction

  function automatic logic [N-1:0] next_rd(logic [N-1:0] cur_rd, logic [N-1:0] cur_en,
                                           logic re, logic [1:0] a);
    if (!re) return cur_rd;
    return (a == 2'd2) ? cur_en : '0;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic [1:0] wa, logic [N-1:0] wd,
                      logic re, logic [1:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    exp_rd = next_rd(exp_rd, exp_en, re, ra);
    exp_en = next_en(exp_en, we, wa, wd);
    #1;
    check({tag, " en"}, clk_en_o, exp_en);
    check({tag, " rd"}, rd_data_o, exp_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = '1; rd_en = 1'b1; rd_addr = 2'd2;
    repeat (3) @(posedge clk);
    #1;
    // R1: bus activity during reset has no effect
    check("R1 reset en", clk_en_o, '0);
    check("R1 reset rd", rd_data_o, '0);
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    exp_en = '0; exp_rd = '0;

    // R2 R7: set all, reserved stay zero
    step("R2_R7 set all", 1'b1, 2'd0, '1, 1'b0, 2'd0);
    step("R6 stat read", 1'b0, 2'd0, '0, 1'b1, 2'd2);
    // R3 R5: clear some, immediate
    step("R3_R5 clear", 1'b1, 2'd1, 32'h0000_FF0C, 1'b0, 2'd0);
    // R4: zero writes keep state
    step("R4 zero set", 1'b1, 2'd0, '0, 1'b0, 2'd0);
    step("R4 zero clr", 1'b1, 2'd1, '0, 1'b0, 2'd0);
    // R8: status/unused writes ignored
    step("R8 wr stat", 1'b1, 2'd2, 32'h0000_FF00, 1'b1, 2'd2);
    step("R8 wr none", 1'b1, 2'd3, '1, 1'b1, 2'd2);
    // R6: non-status reads zero
    step("R6 rd set", 1'b0, 2'd0, '0, 1'b1, 2'd0);
    step("R6 rd stat", 1'b0, 2'd0, '0, 1'b1, 2'd2);
    // R9: hold without read
    step("R9 hold", 1'b1, 2'd1, '1, 1'b0, 2'd2);
    // R10: read during write sees old state
    step("R10 set+read", 1'b1, 2'd0, 32'h0000_00F0, 1'b1, 2'd2);
    step("R10 clr+read", 1'b1, 2'd1, 32'h0000_0030, 1'b1, 2'd2);
    // R7: set reserved bits only
    step("R7 rsvd set", 1'b1, 2'd0, ~MASK, 1'b1, 2'd2);

    for (int i = 0; i < 400; i++) begin
      step("R2_R3_rand", 1'($urandom), 2'($urandom), N'($urandom),
           1'($urandom), 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule